// File: doc/BRIEF.md
# Block-Access Configuration Register Slave

This block is a two-wire serial slave that holds a small bank of 8-bit configuration registers and presents them as parallel outputs. It answers only to block transfers. The master writes by sending the device address with the direction bit clear, then two bytes whose values are ignored (a command byte and a count byte), and then data bytes that fill the registers from index 0 upward. The master reads by sending the address with the direction bit set. The slave replies with a count byte and then every register in index order.

The clock and data lines arrive from open-drain pads. They pass through two-flop synchronizers. Start and stop are recognised as data-line edges while the clock is high. The slave pulls the data line low through `sda_oe_o` to acknowledge or to send a zero bit. It never drives the line high. It changes `sda_oe_o` only while the clock is low. A frame whose address does not match is left alone until the next start condition.

Top module: `blk_cfg_slave`

## Requirements
- R1: After reset, register 0 through register 5 read 0x81, 0x0F, 0xF0, 0xFF, 0x3C, 0xA5 on `regs_o`, with register k in bits [8k+7:8k], and `sda_oe_o` is 0.
- R2: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. This is device address 0x69 with the direction bit in bit 0, sent MSB first. The slave acknowledges by pulling the data line low during the ninth clock.
- R3: An address byte with any other 7-bit address is not acknowledged. No later byte in that frame is acknowledged or changes a register until the next start condition.
- R4: On a write, the two bytes after the address are acknowledged, and their values never change a register.
- R5: On a write, the data bytes after those two are stored into register 0, 1, 2, and so on in ascending order, and each one is acknowledged.
- R6: A stop after any complete byte ends the write. Registers already written keep the new values, and all others keep their previous values.
- R7: On a write, data bytes beyond register 5 are acknowledged but change no register.
- R8: On a read, the first byte sent after the address acknowledge is the register count, 0x06.
- R9: On a read, after the count byte the slave sends register 0 through register 5 in order, MSB first, as long as the master acknowledges each byte.
- R10: When the master does not acknowledge a read byte, the slave stops sending and leaves the data line released until the next start or stop.
- R11: The slave changes `sda_oe_o` only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line from the pad |
| sda_i | input | 1 | Serial data line from the pad |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| regs_o | output | 48 | Register bank, register k in bits [8k+7:8k] |

## Verification
The bench builds the block with its defaults: device address 0x69, six registers, and the reset pattern above. The bus runs at one clock edge every 20 system clocks. With only six registers, a seven-byte write reaches the discard path past the last register. A short write reaches the partial-commit case, and a read of all six bytes reaches the final not-acknowledge from the master. A wrong address, an early not-acknowledge on a read and a reset in the middle of operation cover the cases where the slave must stay quiet or fall back to its defaults.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK, ST_SKIP
  } cfgs_state_e;
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;  // idle bus is high
      else         pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/cfgs_cond.sv
module cfgs_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile #(
  parameter int              NREG    = 6,
  parameter logic [NREG*8-1:0] RST_VAL = '0,
  localparam int             AW      = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [7:0]        wdata_i,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       regs_o[g*8 +: 8] <= RST_VAL[g*8 +: 8];
      else if (we_i && (32'(waddr_i) == g))              regs_o[g*8 +: 8] <= wdata_i;
    end
  end
endmodule

// File: rtl/blk_cfg_slave.sv
module blk_cfg_slave #(
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter int                NREG     = 6,
  parameter logic [NREG*8-1:0] RST_VAL  = 48'hA5_3C_FF_F0_0F_81
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] regs_o
);
  import cfgs_pkg::*;

  localparam int         AW       = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int         CW       = $clog2(NREG + 3);
  localparam int         IW       = $clog2(NREG + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(NREG + 2);
  localparam logic [IW-1:0] IDX_MAX = IW'(NREG);
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  logic [1:0] sync_s;
  logic       scl_s, sda_s;
  logic       start, stop, scl_rise, scl_fall;

  cfgs_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(sync_s)
  );
  assign scl_s = sync_s[1];
  assign sda_s = sync_s[0];

  cfgs_cond u_cond (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  cfgs_state_e   state_q;
  logic [3:0]    bit_cnt_q;
  logic [7:0]    sh_q;
  logic          rw_q;
  logic          oe_q;
  logic [CW-1:0] byte_cnt_q;
  logic [IW-1:0] rd_idx_q;

  logic          we;
  logic [AW-1:0] waddr;
  logic [CW-1:0] data_idx;
  logic          byte_done;
  logic [7:0]    next_tx;

  assign byte_done = scl_fall && (bit_cnt_q == 4'd8);
  assign data_idx  = byte_cnt_q - CW'(2);
  // command and count bytes (index 0, 1) never reach the register file
  assign we        = (state_q == ST_RX) && byte_done && (byte_cnt_q >= CW'(2))
                     && (byte_cnt_q < CNT_MAX);
  assign waddr     = AW'(data_idx);
  assign next_tx   = (rd_idx_q < IDX_MAX) ? regs_o[rd_idx_q*8 +: 8] : 8'hFF;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      rw_q       <= 1'b0;
      oe_q       <= 1'b0;
      byte_cnt_q <= '0;
      rd_idx_q   <= '0;
    end else if (start) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_RX: begin
          if (scl_rise) begin
            sh_q      <= {sh_q[6:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            if (state_q == ST_RX) begin
              state_q <= ST_RACK;
              oe_q    <= 1'b1;
            end else if (sh_q[7:1] == DEV_ADDR) begin
              state_q <= ST_AACK;
              oe_q    <= 1'b1;
              rw_q    <= sh_q[0];
            end else begin
              state_q <= ST_SKIP;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (rw_q) begin
            state_q  <= ST_TX;
            sh_q     <= CNT_BYTE;
            oe_q     <= ~CNT_BYTE[7];
            rd_idx_q <= '0;
          end else begin
            state_q    <= ST_RX;
            oe_q       <= 1'b0;
            byte_cnt_q <= '0;
          end
        end
        ST_RACK: if (scl_fall) begin
          state_q   <= ST_RX;
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
          if (byte_cnt_q != CNT_MAX) byte_cnt_q <= byte_cnt_q + CW'(1);
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt_q == 4'd7) begin
            state_q   <= ST_MACK;
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 4'd1;
            sh_q      <= {sh_q[6:0], 1'b1};
            oe_q      <= ~sh_q[6];
          end
        end
        ST_MACK: begin
          if (scl_rise && sda_s) begin
            state_q <= ST_SKIP;  // master NACK: go quiet
          end else if (scl_fall) begin
            state_q <= ST_TX;
            sh_q    <= next_tx;
            oe_q    <= ~next_tx[7];
            if (rd_idx_q < IDX_MAX) rd_idx_q <= rd_idx_q + IW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe_q;

  cfgs_regfile #(.NREG(NREG), .RST_VAL(RST_VAL)) u_regs (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(sh_q), .regs_o
  );
endmodule

// File: rtl/cfgs_chk.sv
module cfgs_chk #(
  parameter int NREG = 6,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s,
  input logic              sda_s,
  input logic              sda_oe_o,
  input cfgs_pkg::cfgs_state_e state_q,
  input logic              we,
  input logic [AW-1:0]     waddr,
  input logic [NREG*8-1:0] regs_o
);
  import cfgs_pkg::*;

  // R11
  a_r11_oe_only_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_s && $past(scl_s) |-> $stable(sda_oe_o));

  // R10
  a_r10_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MACK) && $rose(scl_s) && sda_s |=> (state_q == ST_SKIP) && !sda_oe_o);

  // R3
  a_r3_skip_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SKIP) |-> !sda_oe_o && !we);

  // R7
  a_r7_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (32'(waddr) < NREG));

  // R6
  a_r6_hold_unwritten: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we |=> $stable(regs_o));

  // R1
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);
endmodule

bind blk_cfg_slave cfgs_chk #(.NREG(NREG)) u_chk (
  .clk_i, .rst_ni, .scl_s, .sda_s, .sda_oe_o, .state_q, .we, .waddr, .regs_o
);

// File: tb/tb_blk_cfg_slave.sv
module tb_blk_cfg_slave;
  localparam int NREG = 6;
  localparam int Q    = 20;
  localparam logic [47:0] DEFAULTS = 48'hA5_3C_FF_F0_0F_81;
  // [59:56] data byte count, byte k at [55-8k -: 8]
  localparam logic [59:0] VEC [4] = '{
    {4'd6, 56'h11_22_33_44_55_66_00},
    {4'd2, 56'hA1_B2_00_00_00_00_00},
    {4'd0, 56'h00_00_00_00_00_00_00},
    {4'd7, 56'hC0_C1_C2_C3_C4_C5_C6}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic [47:0] regs;
  wire  sda = ~(m_low | sda_oe);
  int   total = 0, bad = 0;
  bit   done = 1'b0;
  logic [7:0] model [NREG];

  always #5 clk = ~clk;

  blk_cfg_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  task automatic wq(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    end
    m_low = 1'b0; wq(Q); m_scl = 1'b1; wq(Q);
    ack = ~sda; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda; wq(Q); m_scl = 1'b0;
    end
    wq(Q); m_low = give_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    m_low = 1'b0;
  endtask

  task automatic check_regs(string req);
    for (int k = 0; k < NREG; k++)
      check(regs[k*8 +: 8] == model[k], req, 64'(regs[k*8 +: 8]), 64'(model[k]));
  endtask

  task automatic full_read();
    bit ack; logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack);
    check(ack, "R2 read address ack", 64'(ack), 1);
    recv_byte(b, 1'b1);
    check(b == 8'h06, "R8 count byte", 64'(b), 64'h06);
    for (int k = 0; k < NREG; k++) begin
      recv_byte(b, k != NREG-1);
      check(b == model[k], "R9 read order", 64'(b), 64'(model[k]));
    end
    check(!sda_oe, "R10 released after final nack", 64'(sda_oe), 0);
    bus_stop();
  endtask

  initial begin
    bit ack; logic [7:0] b;
    for (int k = 0; k < NREG; k++) model[k] = DEFAULTS[k*8 +: 8];
    wq(5); rst_ni = 1'b1; wq(5);
    check_regs("R1 reset defaults");
    check(!sda_oe, "R1 line released", 64'(sda_oe), 0);

    foreach (VEC[v]) begin
      int n = int'(VEC[v][59:56]);
      bus_start();
      send_byte(8'hD2, ack);
      check(ack, "R2 write address ack", 64'(ack), 1);
      send_byte(8'h5A, ack);
      check(ack, "R4 command ack", 64'(ack), 1);
      send_byte(8'hEE, ack);
      check(ack, "R4 count ack", 64'(ack), 1);
      for (int k = 0; k < n; k++) begin
        send_byte(VEC[v][55-8*k -: 8], ack);
        check(ack, k < NREG ? "R5 data ack" : "R7 overflow ack", 64'(ack), 1);
        if (k < NREG) model[k] = VEC[v][55-8*k -: 8];
      end
      bus_stop();
      check_regs("R6 R7 after write");
      full_read();
    end

    // R3: foreign address ignored
    bus_start();
    send_byte(8'hD4, ack);
    check(!ack, "R3 foreign address nack", 64'(ack), 0);
    send_byte(8'h00, ack);
    check(!ack, "R3 later byte nack", 64'(ack), 0);
    send_byte(8'h77, ack);
    bus_stop();
    check_regs("R3 regs unchanged");

    // R4/R6: stop after command byte only
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h99, ack);
    bus_stop();
    check_regs("R4 R6 command only");

    // R10: early nack on read
    bus_start();
    send_byte(8'hD3, ack);
    recv_byte(b, 1'b1);
    recv_byte(b, 1'b0);
    check(b == model[0], "R9 first reg", 64'(b), 64'(model[0]));
    for (int i = 0; i < 4*Q; i++) begin
      m_scl = (i % (2*Q)) >= Q; @(negedge clk);
      if (sda_oe) begin
        check(1'b0, "R10 drove after nack", 64'(sda_oe), 0);
        break;
      end
    end
    check(!sda_oe, "R10 released", 64'(sda_oe), 0);
    m_scl = 1'b0; wq(Q);
    bus_stop();
    full_read();

    // R1: reset mid-operation
    rst_ni = 1'b0; wq(3);
    for (int k = 0; k < NREG; k++) model[k] = DEFAULTS[k*8 +: 8];
    check_regs("R1 after reset");
    rst_ni = 1'b1; wq(5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule